// File: doc/BRIEF.md
# Segmented DAC Code Correction Datapath

This block turns a 16-bit sample code into the digital drive for a segmented current-steering converter and its companion trim converter. The top four bits of the code select how many of fifteen equal-weight current segments are on. The lower twelve bits go straight out as binary ladder controls. The top six bits also index a 64-entry table of 8-bit trim words. The selected trim word drives the trim converter in the same cycle as the main code, so each coarse region of the transfer curve gets its own trim.

A calibration sequencer fills the trim table through a simple write port. While calibration mode is held, the sequencer supplies the main code, an extra half-step control and the trim code itself, and the table is bypassed. In normal operation the extra control stays off. A code is captured on a load strobe, and all outputs change together on the following clock edge.

Top module: `segdac_top`

## Requirements
- R1: `segEn` has exactly k bits set, where k is bits [15:12] of the selected code, and the set bits fill indices 0 to k-1 with no gaps.
- R2: `ladderBits` equals bits [11:0] of the selected code.
- R3: Outside calibration mode, `corrCode` equals the table entry indexed by bits [15:10] of the held code.
- R4: While `rstN` is low, and until an entry is first written, every table entry reads 8'h80. During reset, `segEn`, `ladderBits` and `extraLsb` are 0 and `corrCode` is 8'h80.
- R5: A code on `codeIn` is captured on an edge where `loadStb` is high, and it appears on the outputs at the next edge. Without a strobe, the held code is kept.
- R6: When `wrEn` is high at an edge, `wrData` is stored at `wrAddr`. If that entry is the one selected, the new value reaches `corrCode` at the next edge.
- R7: While `calMode` is high at an edge, the outputs at that edge take the code from `calCode` and the trim word from `calCorr`, and the table is not read.
- R8: `extraLsb` follows `calExtraLsb` when `calMode` is high at the edge and is 0 otherwise.
- R9: A load strobe during calibration mode still captures the code. When `calMode` drops, the outputs return to the held code at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Captures `codeIn` |
| codeIn | input | 16 | Sample code for normal operation |
| calMode | input | 1 | Selects the override inputs |
| calCode | input | 16 | Override main code |
| calExtraLsb | input | 1 | Override extra half-step control |
| calCorr | input | 8 | Override trim code |
| wrEn | input | 1 | Trim table write enable |
| wrAddr | input | 6 | Trim table write index |
| wrData | input | 8 | Trim table write value |
| segEn | output | 15 | Thermometer segment enables |
| ladderBits | output | 12 | Binary ladder controls |
| extraLsb | output | 1 | Extra half-step control |
| corrCode | output | 8 | Trim converter code |

## Verification
The embedded assertions check the following on every cycle: that the segment count matches the selected code's top nibble, that the segment enables fill with no gaps, that the ladder bits follow the selected code, and that the extra control stays off outside calibration. They also check that the trim override and the two-edge path from strobe to outputs hold. Only the bench scenarios can show the table contents: entries starting at mid-scale, a write changing the selected trim one edge later, and a strobe taken during calibration that reappears once the mode is dropped.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  typedef struct packed {
    logic loadCode;
    logic useCal;
    logic writeCorr;
  } ctrlStb_t;
endpackage

// File: rtl/segdac_ctrl.sv
module segdac_ctrl (
  input  logic                  loadStb,
  input  logic                  calMode,
  input  logic                  wrEn,
  output segdac_pkg::ctrlStb_t  stb
);
  // R9: loading is independent of the override mode
  always_comb begin
    stb.loadCode  = loadStb;
    stb.useCal    = calMode;
    stb.writeCorr = wrEn;
  end
endmodule

// File: rtl/segdac_path.sv
module segdac_path #(
  parameter int CODE_W    = 16,
  parameter int SEG_BITS  = 4,
  parameter int ADDR_BITS = 6,
  parameter int CORR_W    = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  segdac_pkg::ctrlStb_t           stb,
  input  logic [CODE_W-1:0]              codeIn,
  input  logic [CODE_W-1:0]              calCode,
  input  logic                           calExtraLsb,
  input  logic [CORR_W-1:0]              calCorr,
  input  logic [ADDR_BITS-1:0]           wrAddr,
  input  logic [CORR_W-1:0]              wrData,
  output logic [(1<<SEG_BITS)-2:0]       segEn,
  output logic [CODE_W-SEG_BITS-1:0]     ladderBits,
  output logic                           extraLsb,
  output logic [CORR_W-1:0]              corrCode
);
  localparam int SEG_N = (1 << SEG_BITS) - 1;
  localparam int LAD_W = CODE_W - SEG_BITS;
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam logic [CORR_W-1:0] MID = CORR_W'(1) << (CORR_W - 1);

  logic [CODE_W-1:0]   codeReg;
  logic [CODE_W-1:0]   selCode;
  logic [CORR_W-1:0]   corrMem [DEPTH];
  logic [SEG_N-1:0]    segNext;
  logic [SEG_BITS-1:0] segVal;
  logic [ADDR_BITS-1:0] rdAddr;

  // R5, R9: held code register
  always_ff @(posedge clk) begin
    if (!rstN)             codeReg <= '0;
    else if (stb.loadCode) codeReg <= codeIn;
  end

  // R4, R6: trim table, mid-scale after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) corrMem[i] <= MID;
    end else if (stb.writeCorr) begin
      corrMem[wrAddr] <= wrData;
    end
  end

  assign selCode = stb.useCal ? calCode : codeReg;
  assign segVal  = selCode[CODE_W-1 -: SEG_BITS];
  assign rdAddr  = selCode[CODE_W-1 -: ADDR_BITS];

  // R1: thermometer decode, filled from index 0
  for (genvar i = 0; i < SEG_N; i++) begin : g_therm
    assign segNext[i] = (segVal > SEG_BITS'(i));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segEn      <= '0;
      ladderBits <= '0;
      extraLsb   <= 1'b0;
      corrCode   <= MID;
    end else begin
      segEn      <= segNext;
      ladderBits <= selCode[LAD_W-1:0];
      extraLsb   <= stb.useCal & calExtraLsb;
      corrCode   <= stb.useCal ? calCorr : corrMem[rdAddr];
    end
  end

  // R1
  therm_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $countones(segEn) == int'($past(segVal)));
  // R1
  therm_gapless_chk: assert property (@(posedge clk) disable iff (!rstN)
    (segEn & (segEn + 1'b1)) == '0);
  // R2
  ladder_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ladderBits == $past(selCode[LAD_W-1:0]));
  // R5
  load_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(rstN, 2) && $past(stb.loadCode, 2) && !$past(stb.useCal)
      |-> ladderBits == $past(codeIn[LAD_W-1:0], 2));
  // R7
  cal_corr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(stb.useCal) |-> corrCode == $past(calCorr));
  // R8
  extra_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(stb.useCal) |-> !extraLsb);
endmodule

// File: rtl/segdac_top.sv
module segdac_top #(
  parameter int CODE_W    = 16,
  parameter int SEG_BITS  = 4,
  parameter int ADDR_BITS = 6,
  parameter int CORR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadStb,
  input  logic [CODE_W-1:0]           codeIn,
  input  logic                        calMode,
  input  logic [CODE_W-1:0]           calCode,
  input  logic                        calExtraLsb,
  input  logic [CORR_W-1:0]           calCorr,
  input  logic                        wrEn,
  input  logic [ADDR_BITS-1:0]        wrAddr,
  input  logic [CORR_W-1:0]           wrData,
  output logic [(1<<SEG_BITS)-2:0]    segEn,
  output logic [CODE_W-SEG_BITS-1:0]  ladderBits,
  output logic                        extraLsb,
  output logic [CORR_W-1:0]           corrCode
);
  segdac_pkg::ctrlStb_t stb;

  segdac_ctrl u_ctrl (
    .loadStb (loadStb),
    .calMode (calMode),
    .wrEn    (wrEn),
    .stb     (stb)
  );

  segdac_path #(
    .CODE_W(CODE_W), .SEG_BITS(SEG_BITS), .ADDR_BITS(ADDR_BITS), .CORR_W(CORR_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .codeIn      (codeIn),
    .calCode     (calCode),
    .calExtraLsb (calExtraLsb),
    .calCorr     (calCorr),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .segEn       (segEn),
    .ladderBits  (ladderBits),
    .extraLsb    (extraLsb),
    .corrCode    (corrCode)
  );
endmodule

// File: tb/segdac_top_bench.sv
`timescale 1ns/1ps
module segdac_top_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        loadStb = 0;
  logic [15:0] codeIn = 0;
  logic        calMode = 0;
  logic [15:0] calCode = 0;
  logic        calExtraLsb = 0;
  logic [7:0]  calCorr = 0;
  logic        wrEn = 0;
  logic [5:0]  wrAddr = 0;
  logic [7:0]  wrData = 0;
  logic [14:0] segEn;
  logic [11:0] ladderBits;
  logic        extraLsb;
  logic [7:0]  corrCode;

  segdac_top u_segdac_top (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .codeIn(codeIn),
    .calMode(calMode), .calCode(calCode), .calExtraLsb(calExtraLsb),
    .calCorr(calCorr), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .segEn(segEn), .ladderBits(ladderBits), .extraLsb(extraLsb),
    .corrCode(corrCode)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  int  mMem[64];
  int  mCode = 0;
  int  expSeg = 0, expLad = 0, expEx = 0, expCorr = 128;
  bit  expCal = 0;
  int  nCmp = 0, nBad = 0;
  bit  done = 0;
  string phase = "R4 reset";

  always @(posedge clk) begin
    if (!rstN) begin
      mCode = 0;
      foreach (mMem[i]) mMem[i] = 128;
      expSeg = 0; expLad = 0; expEx = 0; expCorr = 128; expCal = 0;
    end else begin
      int sel;
      sel     = calMode ? int'(calCode) : mCode;
      expSeg  = (1 << (sel >> 12)) - 1;
      expLad  = sel & 12'hFFF;
      expEx   = calMode ? int'(calExtraLsb) : 0;
      expCorr = calMode ? int'(calCorr) : mMem[sel >> 10];
      expCal  = calMode;
      if (wrEn)    mMem[wrAddr] = int'(wrData);
      if (loadStb) mCode = int'(codeIn);
    end
  end

  task automatic cmp(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("R1", int'(segEn), expSeg);
    cmp("R2", int'(ladderBits), expLad);
    cmp("R8", int'(extraLsb), expEx);
    cmp(expCal ? "R7" : "R3", int'(corrCode), expCorr);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic load(logic [15:0] v);
    codeIn = v; loadStb = 1; tick(); loadStb = 0; tick(2);
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R4: reset values and mid-scale table
    tick(3);
    rstN = 1;
    tick(2);
    phase = "R4 midscale";
    load(16'hFC00);
    // R1, R2, R5: every segment count
    phase = "R1 sweep";
    for (int k = 0; k < 16; k++) load(16'((k << 12) | (k * 16'h0111)));
    phase = "R5 hold";
    codeIn = 16'h5A5A; tick(3);
    codeIn = 16'hA5A5; loadStb = 1; tick(); loadStb = 0; tick(2);
    // R6, R3: table writes
    phase = "R6 write";
    for (int a = 0; a < 64; a += 9) begin
      wrEn = 1; wrAddr = 6'(a); wrData = 8'(a * 3 + 7); tick(); wrEn = 0;
      load(16'(a << 10) | 16'h0155);
    end
    phase = "R6 live";
    wrEn = 1; wrAddr = 6'(63); wrData = 8'h3C; tick();
    wrAddr = 6'(62); wrData = 8'hC3; tick(); wrEn = 0;
    load(16'hFFFF); load(16'hF800);
    // R7, R8: calibration override
    phase = "R7 cal";
    calMode = 1;
    for (int j = 0; j < 8; j++) begin
      calCode = 16'(j * 16'h2345); calExtraLsb = j[0]; calCorr = 8'(j * 29);
      tick();
    end
    // R9: strobe during calibration, then leave
    phase = "R9 exit";
    codeIn = 16'h7FFF; loadStb = 1; tick(); loadStb = 0; tick(2);
    calMode = 0; calExtraLsb = 1; tick(3);
    phase = "R8 idle";
    load(16'h8000);
    tick(2);
    finishRun();
  end
endmodule